// File: doc/BRIEF.md
# Rotate-Right-Through-Carry Execution Unit

This unit carries out the rotate-right-through-carry operation for a processor with an accumulator that can be switched between 8 and 16 bits. The operand and the carry flag form one ring that moves right by a single position. The bit that falls out of the bottom of the operand becomes the new carry, and the old carry fills the vacated top bit. The unit also produces the negative and zero flags. It decodes the opcode into one of five addressing modes and runs exactly as many cycles as the operation takes in that mode.

For a memory operand the unit runs a read-modify-write sequence over a byte-wide memory port. Reads return data in the same cycle as the strobe, and writes take effect at the clock edge that ends the strobe cycle. Address generation is done elsewhere; the `mem_hi` output only says which byte of the operand is being moved. The cycle in which `start` is accepted counts as cycle 1. The result, the flags and the write-back target are valid in the cycle in which `done` is high.

Top module: `rrc_unit`

## Requirements
- R1: With `wide`=1, the result is {carry_in, operand[15:1]}. The new C is operand[0], N is result[15], and Z is 1 exactly when all 16 result bits are zero.
- R2: With `wide`=0, only bits 7:0 rotate and carry_in enters bit 7. Result bits 15:8 equal `acc_in[15:8]` captured at start. C is operand[0], N is result[7], and Z is 1 exactly when result[7:0] is zero.
- R3: The opcodes select these modes and base cycle counts: 0x6A accumulator 2, 0x6E absolute 6, 0x66 direct page 5, 0x7E absolute indexed 7, 0x76 direct page indexed 6.
- R4: Every mode except accumulator takes 2 more cycles when `wide`=1.
- R5: The two direct page modes (0x66, 0x76) take 1 more cycle when `dp_low` is nonzero at start. The absolute modes and the accumulator mode ignore `dp_low`.
- R6: After reset the unit is idle, with `busy`, `done`, `illegal`, `mem_rd` and `mem_wr` all low. `done` is high for exactly one cycle, in cycle T, where T is the total from R3 to R5. `busy` stays high from cycle 2 through cycle T.
- R7: A memory mode (`mem_hi`=0 selects the low byte, 1 the high byte) works as follows. With `wide`=0 it reads the low byte in cycle T-2 and writes it in cycle T. With `wide`=1 it reads the low byte in T-4 and the high byte in T-3, then writes the high byte in T-1 and the low byte in T. It raises `wb_mem` together with `done`. In 8-bit mode the high memory byte is never written.
- R8: Accumulator mode makes no memory access. It takes the operand from `acc_in` and raises `wb_acc` together with `done`.
- R9: A `start` with any other opcode raises `illegal` for exactly the next cycle. It starts no operation: there is no `busy`, no `done` and no memory access.
- R10: A `start` that arrives while `busy` is high is ignored. The operation in progress keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to execute the opcode presented |
| opcode | input | 8 | Decoded opcode byte |
| wide | input | 1 | 1 = 16-bit accumulator, 0 = 8-bit |
| carry_in | input | 1 | Current carry flag |
| dp_low | input | 8 | Low byte of the direct page register |
| acc_in | input | 16 | Accumulator value |
| mem_rdata | input | 8 | Read data, valid in the read strobe cycle |
| busy | output | 1 | Operation in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_hi | output | 1 | Byte select for the current strobe |
| mem_wdata | output | 8 | Write data |
| result | output | 16 | Rotated value, valid with `done` |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| wb_acc | output | 1 | Write result to the accumulator |
| wb_mem | output | 1 | Result was written to memory |
| done | output | 1 | Final cycle of the operation |
| illegal | output | 1 | Unknown opcode rejected |

## Verification
The bench walks every combination of the five opcodes, both widths and zero or nonzero direct page low byte. A unit that added the width penalty in accumulator mode, or the alignment penalty in an absolute mode, would raise `done` a cycle or two late. The rows include operands whose rotation gives an all-zero value while the carry comes out set. An 8-bit rotate that let the carry into bit 15, or computed Z over 16 bits, would therefore show the wrong result or flags. Further checks cover byte order within a 16-bit read-modify-write, an untouched high memory byte in 8-bit mode, an unknown opcode that must not start a sequence, and a second start during an operation that must not restart the count.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    localparam logic [7:0] OPC_ACC  = 8'h6A;
    localparam logic [7:0] OPC_ABS  = 8'h6E;
    localparam logic [7:0] OPC_DP   = 8'h66;
    localparam logic [7:0] OPC_ABSX = 8'h7E;
    localparam logic [7:0] OPC_DPX  = 8'h76;

    typedef enum logic [2:0] {
        AM_ACC,
        AM_ABS,
        AM_DP,
        AM_ABSX,
        AM_DPX,
        AM_NONE
    } amode_t;

    function automatic amode_t decode_op(input logic [7:0] op);
        case (op)
            OPC_ACC:  return AM_ACC;
            OPC_ABS:  return AM_ABS;
            OPC_DP:   return AM_DP;
            OPC_ABSX: return AM_ABSX;
            OPC_DPX:  return AM_DPX;
            default:  return AM_NONE;
        endcase
    endfunction

    function automatic logic is_dp_mode(input amode_t m);
        return (m == AM_DP) || (m == AM_DPX);
    endfunction

    // Total cycle count: base per mode, +2 for a wide memory operand,
    // +1 for a direct page base that is not page aligned.
    function automatic logic [CNT_W-1:0] cycle_total(input amode_t m,
                                                     input logic wide,
                                                     input logic dp_nz);
        logic [CNT_W-1:0] t;
        case (m)
            AM_ACC:  t = CNT_W'(2);
            AM_ABS:  t = CNT_W'(6);
            AM_DP:   t = CNT_W'(5);
            AM_ABSX: t = CNT_W'(7);
            AM_DPX:  t = CNT_W'(6);
            default: t = CNT_W'(0);
        endcase
        if (wide && (m != AM_ACC))
            t = t + CNT_W'(2);
        if (dp_nz && is_dp_mode(m))
            t = t + CNT_W'(1);
        return t;
    endfunction

endpackage

// File: rtl/rrc_decode.sv
module rrc_decode
    import rrc_pkg::*;
(
    input  logic [7:0] opcode,
    output amode_t     mode,
    output logic       legal
);

    always_comb begin
        mode  = decode_op(opcode);
        legal = (mode != AM_NONE);
    end

endmodule

// File: rtl/rrc_rotate.sv
module rrc_rotate #(
    parameter int BYTE_W = rrc_pkg::BYTE_W,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic [WORD_W-1:0] opnd,
    input  logic              cin,
    input  logic              wide,
    output logic [WORD_W-1:0] res,
    output logic              n,
    output logic              z,
    output logic              c
);

    logic [WORD_W-1:0] res_word;
    logic [WORD_W-1:0] res_byte;

    always_comb begin
        res_word = {cin, opnd[WORD_W-1:1]};
        res_byte = {opnd[WORD_W-1:BYTE_W], cin, opnd[BYTE_W-1:1]};
        res      = wide ? res_word : res_byte;
        c        = opnd[0];
        n        = wide ? res[WORD_W-1] : res[BYTE_W-1];
        z        = wide ? (res == '0) : (res[BYTE_W-1:0] == '0);
    end

endmodule

// File: rtl/rrc_seq.sv
module rrc_seq #(
    parameter int CNT_W = rrc_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [CNT_W-1:0] total,
    output logic             busy,
    output logic [CNT_W-1:0] remain,
    output logic             done
);

    logic             busy_q;
    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] tot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            tot_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cyc_q  <= CNT_W'(2);
            tot_q  <= total;
        end else if (busy_q) begin
            if (cyc_q == tot_q)
                busy_q <= 1'b0;
            else
                cyc_q <= cyc_q + CNT_W'(1);
        end
    end

    assign busy   = busy_q;
    assign done   = busy_q && (cyc_q == tot_q);
    assign remain = tot_q - cyc_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) accept |=> busy); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |=> !busy); // R6

endmodule

// File: rtl/rrc_unit.sv
module rrc_unit
    import rrc_pkg::*;
#(
    parameter int BYTE_W = rrc_pkg::BYTE_W,
    parameter int CNT_W  = rrc_pkg::CNT_W,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic              wide,
    input  logic              carry_in,
    input  logic [BYTE_W-1:0] dp_low,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_hi,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              wb_acc,
    output logic              wb_mem,
    output logic              done,
    output logic              illegal
);

    amode_t           mode_d;
    logic             legal_d;
    logic             accept;
    logic             reject;
    logic [CNT_W-1:0] total_d;
    logic [CNT_W-1:0] remain;

    amode_t            mode_q;
    logic              wide_q;
    logic              cin_q;
    logic              illegal_q;
    logic [WORD_W-1:0] opnd_q;

    logic mem_act, rd_lo, rd_hi, wr_lo, wr_hi;
    logic [WORD_W-1:0] res;

    rrc_decode u_dec (
        .opcode (opcode),
        .mode   (mode_d),
        .legal  (legal_d)
    );

    assign accept  = start && !busy && legal_d;
    assign reject  = start && !busy && !legal_d;
    assign total_d = cycle_total(mode_d, wide, |dp_low);

    rrc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .total  (total_d),
        .busy   (busy),
        .remain (remain),
        .done   (done)
    );

    // Memory strobe schedule, counted back from the final cycle.
    always_comb begin
        mem_act = busy && (mode_q != AM_ACC);
        rd_lo   = mem_act && (remain == (wide_q ? CNT_W'(4) : CNT_W'(2)));
        rd_hi   = mem_act && wide_q && (remain == CNT_W'(3));
        wr_hi   = mem_act && wide_q && (remain == CNT_W'(1));
        wr_lo   = mem_act && (remain == CNT_W'(0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= AM_ACC;
            wide_q    <= 1'b0;
            cin_q     <= 1'b0;
            opnd_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= reject;
            if (accept) begin
                mode_q <= mode_d;
                wide_q <= wide;
                cin_q  <= carry_in;
                opnd_q <= acc_in;
            end else begin
                if (rd_lo) opnd_q[BYTE_W-1:0]      <= mem_rdata;
                if (rd_hi) opnd_q[WORD_W-1:BYTE_W] <= mem_rdata;
            end
        end
    end

    rrc_rotate #(.BYTE_W(BYTE_W)) u_rot (
        .opnd (opnd_q),
        .cin  (cin_q),
        .wide (wide_q),
        .res  (res),
        .n    (flag_n),
        .z    (flag_z),
        .c    (flag_c)
    );

    assign result    = res;
    assign mem_rd    = rd_lo || rd_hi;
    assign mem_wr    = wr_lo || wr_hi;
    assign mem_hi    = rd_hi || wr_hi;
    assign mem_wdata = mem_hi ? res[WORD_W-1:BYTE_W] : res[BYTE_W-1:0];
    assign wb_acc    = done && (mode_q == AM_ACC);
    assign wb_mem    = done && (mode_q != AM_ACC);
    assign illegal   = illegal_q;

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R7
    AST_LAST_WRITE: assert property (@(posedge clk) disable iff (rst) (mem_wr && !mem_hi) |-> done); // R7
    AST_ACC_NO_MEM: assert property (@(posedge clk) disable iff (rst) (busy && !wb_mem && !mem_act) |-> !(mem_rd || mem_wr)); // R8
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst) illegal |-> !busy && !mem_rd && !mem_wr); // R9
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst) illegal |=> !illegal); // R9

endmodule

// File: tb/test_rrc_unit.sv
`timescale 1ns/1ps
module test_rrc_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        wide = 1'b0;
    logic        carry_in = 1'b0;
    logic [7:0]  dp_low = 8'h00;
    logic [15:0] acc_in = 16'h0000;
    logic [7:0]  mem_rdata;
    logic        busy, mem_rd, mem_wr, mem_hi, flag_n, flag_z, flag_c;
    logic        wb_acc, wb_mem, done, illegal;
    logic [7:0]  mem_wdata;
    logic [15:0] result;

    rrc_unit i_rrc_unit (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .wide(wide),
        .carry_in(carry_in), .dp_low(dp_low), .acc_in(acc_in),
        .mem_rdata(mem_rdata), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_hi(mem_hi), .mem_wdata(mem_wdata), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .wb_acc(wb_acc),
        .wb_mem(wb_mem), .done(done), .illegal(illegal)
    );

    // Two-byte memory model; preload from the bench, writes from the unit.
    logic [7:0]  m_lo = 8'h00, m_hi = 8'h00;
    logic        pre_en = 1'b0;
    logic [15:0] pre_val = 16'h0000;
    assign mem_rdata = mem_hi ? m_hi : m_lo;
    always @(posedge clk) begin
        if (pre_en) begin
            m_lo <= pre_val[7:0];
            m_hi <= pre_val[15:8];
        end else if (mem_wr) begin
            if (mem_hi) m_hi <= mem_wdata;
            else        m_lo <= mem_wdata;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // {opcode, wide, carry, dp_low, operand, expected total cycles}
    localparam int NV = 20;
    localparam logic [37:0] VEC [NV] = '{
        {8'h6A, 1'b0, 1'b0, 8'h00, 16'h3C01, 4'd2},
        {8'h6A, 1'b0, 1'b1, 8'h00, 16'h12FE, 4'd2},
        {8'h6A, 1'b1, 1'b0, 8'h00, 16'h0001, 4'd2},
        {8'h6A, 1'b1, 1'b1, 8'h05, 16'h8002, 4'd2},
        {8'h6E, 1'b0, 1'b1, 8'h00, 16'h00A4, 4'd6},
        {8'h6E, 1'b0, 1'b0, 8'h33, 16'h0055, 4'd6},
        {8'h6E, 1'b1, 1'b1, 8'h00, 16'h1235, 4'd8},
        {8'h6E, 1'b1, 1'b0, 8'h80, 16'hFFFF, 4'd8},
        {8'h66, 1'b0, 1'b0, 8'h00, 16'h0080, 4'd5},
        {8'h66, 1'b0, 1'b1, 8'h01, 16'h0003, 4'd6},
        {8'h66, 1'b1, 1'b0, 8'h00, 16'h0001, 4'd7},
        {8'h66, 1'b1, 1'b1, 8'hFF, 16'h4000, 4'd8},
        {8'h7E, 1'b0, 1'b1, 8'h00, 16'h0011, 4'd7},
        {8'h7E, 1'b0, 1'b0, 8'h10, 16'h0000, 4'd7},
        {8'h7E, 1'b1, 1'b0, 8'h00, 16'hABCD, 4'd9},
        {8'h7E, 1'b1, 1'b1, 8'h20, 16'h0F0E, 4'd9},
        {8'h76, 1'b0, 1'b0, 8'h00, 16'h00F1, 4'd6},
        {8'h76, 1'b0, 1'b1, 8'h40, 16'h0022, 4'd7},
        {8'h76, 1'b1, 1'b1, 8'h00, 16'h7777, 4'd8},
        {8'h76, 1'b1, 1'b0, 8'h02, 16'h8000, 4'd9}
    };

    initial begin
        repeat (3) @(negedge clk);
        chk("R6", "reset busy", busy, 0);
        chk("R6", "reset done", done, 0);
        chk("R6", "reset illegal", illegal, 0);
        chk("R6", "reset strobes", {mem_rd, mem_wr}, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            logic [7:0]  op;
            logic        w, ci;
            logic [7:0]  dpl;
            logic [15:0] opnd, accv, exp_res;
            logic [3:0]  exp_t;
            bit          is_mem, is_dp;
            int          cyc, rlo, rhi, wlo, whi, nrd, nwr;
            logic [15:0] g_res;
            logic        g_n, g_z, g_c, g_wa, g_wm, got_done;
            string       tr, rr;

            {op, w, ci, dpl, opnd, exp_t} = VEC[v];
            is_mem = (op != 8'h6A);
            is_dp  = (op == 8'h66) || (op == 8'h76);
            accv   = is_mem ? ~opnd : opnd;
            exp_res = w ? {ci, opnd[15:1]} : {accv[15:8], ci, opnd[7:1]};
            tr = (w && is_mem) ? "R4" : ((is_dp && dpl != 0) ? "R5" : "R3");
            rr = w ? "R1" : "R2";

            @(negedge clk);
            pre_en = 1'b1; pre_val = opnd;
            @(negedge clk);
            pre_en = 1'b0;
            start = 1'b1; opcode = op; wide = w; carry_in = ci; dp_low = dpl; acc_in = accv;
            cyc = 1; rlo = 0; rhi = 0; wlo = 0; whi = 0; nrd = 0; nwr = 0; got_done = 0;
            g_res = '0; g_n = 0; g_z = 0; g_c = 0; g_wa = 0; g_wm = 0;
            while (cyc < 16) begin
                @(negedge clk);
                start = 1'b0;
                cyc++;
                if (mem_rd) begin nrd++; if (mem_hi) rhi = cyc; else rlo = cyc; end
                if (mem_wr) begin nwr++; if (mem_hi) whi = cyc; else wlo = cyc; end
                if (done) begin
                    got_done = 1;
                    g_res = result; g_n = flag_n; g_z = flag_z; g_c = flag_c;
                    g_wa = wb_acc; g_wm = wb_mem;
                    break;
                end
            end
            chk(tr, "total cycles", cyc, exp_t);
            chk(rr, "result", g_res, exp_res);
            chk(rr, "carry", g_c, opnd[0]);
            chk(rr, "negative", g_n, w ? exp_res[15] : exp_res[7]);
            chk(rr, "zero", g_z, w ? (exp_res == 0) : (exp_res[7:0] == 0));
            @(negedge clk);
            chk("R6", "done one cycle", done, 0);
            if (is_mem) begin
                chk("R7", "wb_mem", {g_wm, g_wa}, 2'b10);
                chk("R7", "read low cycle", rlo, w ? exp_t - 4 : exp_t - 2);
                chk("R7", "write low cycle", wlo, exp_t);
                chk("R7", "read high cycle", rhi, w ? exp_t - 3 : 0);
                chk("R7", "write high cycle", whi, w ? exp_t - 1 : 0);
                chk("R7", "memory low byte", m_lo, exp_res[7:0]);
                chk("R7", "memory high byte", m_hi, w ? exp_res[15:8] : opnd[15:8]);
            end else begin
                chk("R8", "wb_acc", {g_wm, g_wa}, 2'b01);
                chk("R8", "no memory access", nrd + nwr, 0);
            end
        end

        // R9: unknown opcode.
        begin
            int seen;
            @(negedge clk);
            start = 1'b1; opcode = 8'h6B; wide = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R9", "illegal raised", illegal, 1);
            chk("R9", "not busy", busy, 0);
            seen = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (busy || done || mem_rd || mem_wr || illegal) seen++;
            end
            chk("R9", "no activity after reject", seen, 0);
        end

        // R10: start during a running operation.
        begin
            int cyc, ndone, dcyc;
            logic [15:0] g_res;
            @(negedge clk);
            pre_en = 1'b1; pre_val = 16'h0040;
            @(negedge clk);
            pre_en = 1'b0;
            start = 1'b1; opcode = 8'h6E; wide = 1'b0; carry_in = 1'b1; dp_low = 8'h00; acc_in = 16'h9900;
            cyc = 1; ndone = 0; dcyc = 0; g_res = '0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                cyc++;
                start = (cyc == 3);
                if (start) begin opcode = 8'h6A; carry_in = 1'b0; acc_in = 16'h0003; end
                if (done) begin ndone++; dcyc = cyc; g_res = result; end
            end
            start = 1'b0;
            chk("R10", "single done", ndone, 1);
            chk("R10", "done cycle", dcyc, 6);
            chk("R10", "result kept", g_res, 16'h99A0);
        end

        finish_run();
    end

endmodule